// File: doc/BRIEF.md
# Program-memory table read unit

This unit carries out the two table-read operations of a small 8-bit microcontroller core. On a start strobe it forms a program-memory address: an 8-bit table pointer sits in the low byte. Above it go page bits, which come either from the upper bits of the current program counter (current-page read) or are all forced to one (last-page read). The unit then fetches that word through a synchronous ROM read port.

The fetched word is split in two. Its low byte goes through a one-clock write port into a destination data-memory register. The bits above the low byte are loaded into a high-byte latch. Program code can read that latch but cannot write it. Every table read overwrites it, and there is no way to restore it. Each operation occupies two cycles, and the unit ignores new strobes while it is busy.

Top module: `tblrd_unit`

## Requirements
- R1: A current-page read (`last_page_i` = 0) drives `rom_addr_o` = {`pc_hi_i`, `ptr_i`}, with the pointer in bits 7..0 and the program-counter page bits above them.
- R2: A last-page read (`last_page_i` = 1) drives `rom_addr_o` with every bit above bit 7 set to 1 and `ptr_i` in bits 7..0. With an 11-bit address, pointer 06h gives 706h and pointer 05h gives 705h.
- R3: An accepted strobe (`start_i` high while `busy_o` is low at a rising edge) holds `busy_o` high for exactly two cycles. `rom_re_o` is high in the first of those cycles only.
- R4: In the second busy cycle, `wr_en_o` is high for one clock, `wr_data_o` equals bits 7..0 of the ROM word, and `wr_addr_o` equals the destination captured at the strobe. Outside that cycle, `wr_en_o` is low.
- R5: At the end of the second busy cycle, `hi_o` takes the ROM word bits above bit 7, zero-extended. Bits of `hi_o` above the word's stored width read as 0.
- R6: `hi_o` changes only when a table read completes. It holds its value during idle cycles and during the first busy cycle.
- R7: A strobe that arrives while `busy_o` is high is ignored. The running operation is not disturbed, and no new operation starts after it.
- R8: The page bits, pointer, page select and destination are sampled at the accepted strobe. Later changes to these inputs do not affect the operation in progress.
- R9: A synchronous reset clears `hi_o` and `busy_o` and holds `wr_en_o` and `rom_re_o` low, including when it arrives mid-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for a table read |
| last_page_i | input | 1 | 1 selects the last ROM page, 0 the current page |
| pc_hi_i | input | ADDR_W-8 | Upper (page) bits of the current program counter |
| ptr_i | input | 8 | Table pointer value |
| dst_i | input | DST_W | Destination data-memory register address |
| rom_addr_o | output | ADDR_W | ROM word address |
| rom_re_o | output | 1 | ROM read enable |
| rom_data_i | input | WORD_W | ROM word, valid the cycle after the read enable |
| wr_en_o | output | 1 | Data-memory write enable |
| wr_addr_o | output | DST_W | Data-memory write address |
| wr_data_o | output | 8 | Data-memory write data (low byte of word) |
| hi_o | output | HI_W | Read-only high-byte latch |
| busy_o | output | 1 | Operation in progress |

## Verification
The hardest situation to reach from the ports is a second strobe overlapping a running read while its address inputs change. Only then can a design that re-samples the pointer or page bits, or that restarts, be told apart from a correct one. In a share of the random operations, the stimulus holds the strobe high through both busy cycles and scrambles the pointer, page bits, page select and destination right after acceptance. The checks then expect the original word, the original destination and an idle unit afterwards. A reset dropped into the middle of an operation covers the other hard-to-reach state.

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 14,
  parameter int DST_W  = 7,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              last_page_i,
  input  logic [ADDR_W-9:0] pc_hi_i,
  input  logic [7:0]        ptr_i,
  input  logic [DST_W-1:0]  dst_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_re_o,
  input  logic [WORD_W-1:0] rom_data_i,
  output logic              wr_en_o,
  output logic [DST_W-1:0]  wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [HI_W-1:0]   hi_o,
  output logic              busy_o
);
  localparam int PG_W   = ADDR_W - 8;
  localparam int KEEP_W = WORD_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WRITE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [DST_W-1:0]  dst_q;
  logic [HI_W-1:0]   hi_q;
  logic              take;

  assign take = start_i && (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      hi_q <= '0;
    end else begin
      case (st)
        S_IDLE:  if (take) st <= S_FETCH;
        S_FETCH: st <= S_WRITE;
        default: begin
          st   <= S_IDLE;
          hi_q <= HI_W'(rom_data_i[WORD_W-1:8]);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q <= {(last_page_i ? {PG_W{1'b1}} : pc_hi_i), ptr_i};
      dst_q  <= dst_i;
    end
  end

  assign busy_o     = (st != S_IDLE);
  assign rom_re_o   = (st == S_FETCH);
  assign rom_addr_o = addr_q;
  assign wr_en_o    = (st == S_WRITE);
  assign wr_addr_o  = dst_q;
  assign wr_data_o  = rom_data_i[7:0];
  assign hi_o       = hi_q;

  p_cur_page_r1: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !last_page_i) |=> (rom_re_o && rom_addr_o == {$past(pc_hi_i), $past(ptr_i)}));

  p_last_page_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && last_page_i) |=> (rom_re_o && rom_addr_o[ADDR_W-1:8] == {PG_W{1'b1}}
                                             && rom_addr_o[7:0] == $past(ptr_i)));

  p_two_cycles_r3: assert property (@(posedge clk) disable iff (rst)
    rom_re_o |=> (busy_o && !rom_re_o && wr_en_o));

  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> (!wr_en_o && !busy_o));

  p_hi_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> (hi_o[KEEP_W-1:0] == $past(rom_data_i[WORD_W-1:8]) && (hi_o >> KEEP_W) == '0));

  p_hi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |=> $stable(hi_o));

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !rom_re_o) |=> !busy_o);

  p_addr_held_r8: assert property (@(posedge clk) disable iff (rst)
    rom_re_o |=> $stable(rom_addr_o) && $stable(wr_addr_o));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!busy_o && !wr_en_o && !rom_re_o && hi_o == '0));

  initial begin
    a_cfg: assert (ADDR_W >= 10 && ADDR_W <= 12 && WORD_W > 8 && WORD_W - 8 <= HI_W);
  end
endmodule

// File: tb/tblrd_unit_tb.sv
`timescale 1ns/1ps
module tblrd_unit_tb_top;
  localparam int ADDR_W = 11;
  localparam int WORD_W = 14;
  localparam int DST_W  = 7;
  localparam int HI_W   = 8;
  localparam int PG_W   = ADDR_W - 8;

  logic              clk = 0;
  logic              rst = 1;
  logic              start_i = 0;
  logic              last_page_i = 0;
  logic [PG_W-1:0]   pc_hi_i = '0;
  logic [7:0]        ptr_i = '0;
  logic [DST_W-1:0]  dst_i = '0;
  logic [ADDR_W-1:0] rom_addr_o;
  logic              rom_re_o;
  logic [WORD_W-1:0] rom_q = '0;
  logic              wr_en_o;
  logic [DST_W-1:0]  wr_addr_o;
  logic [7:0]        wr_data_o;
  logic [HI_W-1:0]   hi_o;
  logic              busy_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tblrd_unit #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DST_W(DST_W), .HI_W(HI_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .last_page_i(last_page_i),
    .pc_hi_i(pc_hi_i), .ptr_i(ptr_i), .dst_i(dst_i),
    .rom_addr_o(rom_addr_o), .rom_re_o(rom_re_o), .rom_data_i(rom_q),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .hi_o(hi_o), .busy_o(busy_o));

  function automatic logic [WORD_W-1:0] rom_fn(logic [ADDR_W-1:0] a);
    int v;
    v = (int'(a) * 91) ^ (int'(a) >> 2) ^ 'h2A5 ^ (int'(a) << 5);
    return v[WORD_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(bit lst, logic [PG_W-1:0] pg, logic [7:0] p);
    return lst ? {{PG_W{1'b1}}, p} : {pg, p};
  endfunction

  always @(posedge clk) if (rom_re_o) rom_q <= rom_fn(rom_addr_o);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(bit lst, logic [PG_W-1:0] pg, logic [7:0] p, logic [DST_W-1:0] d, bit disturb);
    logic [ADDR_W-1:0] ea;
    logic [WORD_W-1:0] w;
    logic [HI_W-1:0]   old_hi;
    ea = exp_addr(lst, pg, p);
    w  = rom_fn(ea);
    old_hi = hi_o;
    start_i = 1; last_page_i = lst; pc_hi_i = pg; ptr_i = p; dst_i = d;
    @(posedge clk); @(negedge clk);
    if (disturb) begin
      pc_hi_i = PG_W'($urandom); ptr_i = 8'($urandom); last_page_i = ~lst; dst_i = ~d;
    end else start_i = 0;
    chk(busy_o == 1, "R3 busy first cycle", busy_o, 1);
    chk(rom_re_o == 1, "R3 read enable first cycle", rom_re_o, 1);
    chk(rom_addr_o == ea, lst ? "R2 last-page address" : "R1 current-page address", rom_addr_o, ea);
    chk(wr_en_o == 0, "R4 no write in first cycle", wr_en_o, 0);
    chk(hi_o == old_hi, "R6 hi held first cycle", hi_o, old_hi);
    @(posedge clk); @(negedge clk);
    if (disturb) begin
      pc_hi_i = PG_W'($urandom); ptr_i = 8'($urandom); dst_i = DST_W'($urandom);
    end
    chk(busy_o == 1, "R3 busy second cycle", busy_o, 1);
    chk(rom_re_o == 0, "R3 read enable drops", rom_re_o, 0);
    chk(wr_en_o == 1, "R4 write pulse", wr_en_o, 1);
    chk(wr_data_o == w[7:0], disturb ? "R8 low byte after input change" : "R4 low byte", wr_data_o, w[7:0]);
    chk(wr_addr_o == d, disturb ? "R8 destination held" : "R4 destination", wr_addr_o, d);
    @(posedge clk); @(negedge clk);
    chk(busy_o == 0, disturb ? "R7 strobe while busy ignored" : "R3 idle after two cycles", busy_o, 0);
    chk(wr_en_o == 0, "R4 single write pulse", wr_en_o, 0);
    chk(hi_o == HI_W'(w >> 8), "R5 high part latched", hi_o, HI_W'(w >> 8));
    start_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy_o == 0 && wr_en_o == 0 && rom_re_o == 0, "R9 reset outputs idle", {busy_o, wr_en_o, rom_re_o}, 0);
    chk(hi_o == 0, "R9 reset clears hi", hi_o, 0);
    rst = 0;
    @(negedge clk);

    do_op(1, 3'b010, 8'h06, 7'h21, 0);
    chk(ADDR_W != 11 || exp_addr(1, 3'b010, 8'h06) == 11'h706, "R2 example 706h", exp_addr(1, 3'b010, 8'h06), 'h706);
    do_op(1, 3'b001, 8'h05, 7'h22, 0);
    do_op(0, 3'b000, 8'h00, 7'h00, 0);
    do_op(0, 3'b111, 8'hFF, 7'h7F, 0);
    do_op(0, 3'b101, 8'h3C, 7'h15, 1);
    do_op(1, 3'b000, 8'hFF, 7'h40, 1);

    for (int i = 0; i < 300; i++) begin
      logic [HI_W-1:0] h;
      do_op(bit'($urandom), PG_W'($urandom), 8'($urandom), DST_W'($urandom), ($urandom % 3) == 0);
      h = hi_o;
      for (int k = 0; k < int'($urandom % 3); k++) begin
        pc_hi_i = PG_W'($urandom); ptr_i = 8'($urandom);
        @(posedge clk); @(negedge clk);
        chk(hi_o == h && busy_o == 0, "R6 hi held while idle", hi_o, h);
      end
    end

    start_i = 1; last_page_i = 0; pc_hi_i = 3'b011; ptr_i = 8'h44;
    @(posedge clk); @(negedge clk);
    start_i = 0; rst = 1;
    @(posedge clk); @(negedge clk);
    chk(busy_o == 0 && wr_en_o == 0 && rom_re_o == 0, "R9 mid-operation reset", {busy_o, wr_en_o, rom_re_o}, 0);
    chk(hi_o == 0, "R9 mid-operation reset clears hi", hi_o, 0);
    rst = 0;
    @(posedge clk); @(negedge clk);
    chk(busy_o == 0 && wr_en_o == 0, "R9 stays idle after reset", {busy_o, wr_en_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule